// File: doc/BRIEF.md
# Subcarrier Manchester Response Encoder

This block produces the load-modulation control line that a contactless vicinity tag uses to answer a reader. It runs on the recovered carrier clock. A start strobe opens a frame. The block then emits a fixed start-of-frame pattern, then the bytes it pulls through a valid/ready handshake, and finally the mirrored end-of-frame pattern. Every bit is Manchester coded in two half-bits. One half-bit is always filled with the lower-frequency subcarrier, which is the carrier divided by 32. The other half-bit carries no modulation in single-subcarrier mode. In dual-subcarrier mode it is filled with the higher-frequency subcarrier, which is the carrier divided by 28.

The length of a half-bit depends on three things latched at start: the data rate, the subcarrier mode and a fast option. The low rate is four times slower than the high rate. The fast option halves the high-rate half-bit and is allowed only with a single subcarrier. A start that asks for fast mode together with the dual subcarrier is refused. The frame ends at the first byte boundary where the source offers no byte.

Top module: `tag_resp_encoder`

## Requirements
- R1: After reset, `busy`, `mod_out` and `in_ready` are all low.
- R2: A logic 0 is sent as a modulated half-bit followed by a plain half-bit, and a logic 1 is sent the other way round. Each byte is sent least significant bit first.
- R3: The modulated half-bit uses a subcarrier with a 32-clock period, high for its first 16 clocks. The dual-mode subcarrier has a 28-clock period and is high for its first 14 clocks. Each half-bit starts at the beginning of a subcarrier period.
- R4: In single-subcarrier mode the plain half-bit holds `mod_out` low for exactly as long as a modulated half-bit lasts.
- R5: In dual-subcarrier mode the plain half-bit is filled with the 28-clock subcarrier: 9 periods at high rate and 36 periods at low rate.
- R6: A modulated half-bit lasts 8 periods of 32 clocks (256 clocks) at high rate, 32 periods (1024 clocks) at low rate, and 4 periods (128 clocks) with the fast option.
- R7: The start-of-frame pattern is three plain half-bits, three modulated half-bits, one plain half-bit and one modulated half-bit, in that order. The end-of-frame pattern is the same eight half-bits in reverse order.
- R8: `in_ready` is high for one clock at the last clock of the start-of-frame pattern and at the last clock of each byte, whatever the state of `in_valid`. If `in_valid` is high in that clock, the byte on `in_data` is taken. Otherwise the end-of-frame pattern follows.
- R9: `busy` rises in the clock after an accepted start and stays high until the last clock of the end-of-frame pattern. It is low in the clock after that.
- R10: A start with both `fast` and `dual_sc` high is refused. `busy` stays low and `mod_out` does not toggle.
- R11: `rate_hi`, `dual_sc` and `fast` are sampled only when a start is accepted. Any start strobe and any change on these inputs while `busy` is high leave the waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Frame start strobe, honoured only while idle |
| rate_hi | input | 1 | 1 selects the high data rate, 0 selects the low data rate |
| dual_sc | input | 1 | 1 selects the dual subcarrier |
| fast | input | 1 | 1 halves the high-rate half-bit (single subcarrier only) |
| in_data | input | 8 | Byte offered for transmission |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Byte taken in this clock if `in_valid` is high |
| mod_out | output | 1 | Load-modulation control |
| busy | output | 1 | Frame in progress |

## Verification
A corrupted subcarrier counter or pulse counter shows up at `mod_out` within one subcarrier period, as a pulse of the wrong width or a half-bit of the wrong length. The bench compares `mod_out` clock by clock against a waveform it builds independently from the rules above, so such a fault is caught at its first wrong clock. Faults in the half-bit sequencing appear as a wrongly ordered SOF, EOF or data half-bit, or as a miscounted `in_ready` pulse, within one half-bit time. A configuration that leaks through while busy corrupts the very next half-bit length.

// File: rtl/tag_resp_encoder.sv
module tag_resp_encoder #(
  parameter int DIV_A     = 32,
  parameter int DIV_B     = 28,
  parameter int PULSES_A  = 8,
  parameter int PULSES_B  = 9,
  parameter int LOW_MULT  = 4,
  parameter logic [7:0] SOF_PAT = 8'hB8,
  parameter logic [7:0] EOF_PAT = 8'h1D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rate_hi,
  input  logic       dual_sc,
  input  logic       fast,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       mod_out,
  output logic       busy
);

  localparam int SW   = $clog2(DIV_A > DIV_B ? DIV_A : DIV_B);
  localparam int PMAX = (PULSES_B > PULSES_A ? PULSES_B : PULSES_A) * LOW_MULT;
  localparam int PW   = $clog2(PMAX + 1);
  localparam logic [SW:0]   PER_A   = (SW+1)'(DIV_A);
  localparam logic [SW:0]   PER_B   = (SW+1)'(DIV_B);
  localparam logic [PW-1:0] NA_HI   = PW'(PULSES_A);
  localparam logic [PW-1:0] NA_LO   = PW'(PULSES_A * LOW_MULT);
  localparam logic [PW-1:0] NA_FAST = PW'(PULSES_A / 2);
  localparam logic [PW-1:0] NB_HI   = PW'(PULSES_B);
  localparam logic [PW-1:0] NB_LO   = PW'(PULSES_B * LOW_MULT);

  typedef enum logic [1:0] {S_IDLE, S_SOF, S_DATA, S_EOF} st_t;

  st_t           st;
  logic [15:0]   sym;
  logic [4:0]    halves_left;
  logic [SW-1:0] sub_cnt;
  logic [PW-1:0] pulse_cnt;
  logic          c_hi, c_dual, c_fast;

  logic          use_b, sub_wrap, half_end, seg_end;
  logic [SW:0]   period;
  logic [PW-1:0] n_pulses;

  function automatic logic [15:0] expand(input logic [7:0] b);
    logic [15:0] r;
    for (int i = 0; i < 8; i++) begin
      r[2*i]   = ~b[i];
      r[2*i+1] =  b[i];
    end
    return r;
  endfunction

  assign use_b    = c_dual & ~sym[0];
  assign period   = use_b ? PER_B : PER_A;
  assign n_pulses = use_b ? (c_hi ? NB_HI : NB_LO)
                          : (c_fast ? NA_FAST : (c_hi ? NA_HI : NA_LO));
  assign sub_wrap = {1'b0, sub_cnt} == period - 1'b1;
  assign half_end = sub_wrap && (pulse_cnt == n_pulses - 1'b1);
  assign seg_end  = half_end && (halves_left == 5'd1);

  assign busy     = (st != S_IDLE);
  assign in_ready = seg_end && (st == S_SOF || st == S_DATA);
  assign mod_out  = busy && (sym[0] || c_dual) && ({1'b0, sub_cnt} < (period >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      sym         <= '0;
      halves_left <= '0;
      sub_cnt     <= '0;
      pulse_cnt   <= '0;
      c_hi        <= 1'b0;
      c_dual      <= 1'b0;
      c_fast      <= 1'b0;
    end else if (st == S_IDLE) begin
      if (start && !(fast && dual_sc)) begin
        c_hi        <= rate_hi;
        c_dual      <= dual_sc;
        c_fast      <= fast;
        st          <= S_SOF;
        sym         <= {8'h00, SOF_PAT};
        halves_left <= 5'd8;
        sub_cnt     <= '0;
        pulse_cnt   <= '0;
      end
    end else begin
      if (sub_wrap) begin
        sub_cnt   <= '0;
        pulse_cnt <= half_end ? '0 : pulse_cnt + 1'b1;
      end else begin
        sub_cnt <= sub_cnt + 1'b1;
      end
      if (half_end) begin
        if (!seg_end) begin
          sym         <= sym >> 1;
          halves_left <= halves_left - 1'b1;
        end else if (st == S_EOF) begin
          st <= S_IDLE;
        end else if (in_valid) begin
          sym         <= expand(in_data);
          halves_left <= 5'd16;
          st          <= S_DATA;
        end else begin
          sym         <= {8'h00, EOF_PAT};
          halves_left <= 5'd8;
          st          <= S_EOF;
        end
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mod_out && !in_ready));

  assert_sub_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, sub_cnt} < period));

  assert_ready_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !(fast && dual_sc)) |=> busy);

  assert_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && fast && dual_sc) |=> !busy);

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(c_hi) && $stable(c_dual) && $stable(c_fast))));

  assert_no_fast_dual_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(c_fast && c_dual));

endmodule

// File: tb/tag_resp_encoder_tb.sv
`timescale 1ns/1ps
module tag_resp_encoder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       rate_hi = 1'b1;
  logic       dual_sc = 1'b0;
  logic       fast = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready, mod_out, busy;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  tag_resp_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_hi(rate_hi),
    .dual_sc(dual_sc), .fast(fast), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .mod_out(mod_out), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(mod_out == 1'b0, "R1", "mod_out after reset", mod_out, 0);
    check(in_ready == 1'b0, "R1", "in_ready after reset", in_ready, 0);
  endtask

  task automatic run_frame(input bit hi, input bit dual, input bit fst,
                           input int nbytes, input logic [7:0] b0,
                           input logic [7:0] b1, input bit poke,
                           input string req);
    bit hs[64];
    int nh;
    int sof[8];
    int eof_p[8];
    logic [7:0] bytes[2];
    int idx, rdy_cnt, mism, busy_bad, first_exp, first_act, first_at, cyc;
    bit take;
    int na, nb;
    sof   = '{0, 0, 0, 1, 1, 1, 0, 1};
    eof_p = '{1, 0, 1, 1, 1, 0, 0, 0};
    bytes[0] = b0;
    bytes[1] = b1;
    nh = 0;
    for (int i = 0; i < 8; i++) hs[nh++] = sof[i][0];
    for (int k = 0; k < nbytes; k++)
      for (int j = 0; j < 8; j++) begin
        hs[nh++] = ~bytes[k][j];
        hs[nh++] =  bytes[k][j];
      end
    for (int i = 0; i < 8; i++) hs[nh++] = eof_p[i][0];
    na = fst ? 4 : (hi ? 8 : 32);
    nb = hi ? 9 : 36;

    idx = 0; rdy_cnt = 0; mism = 0; busy_bad = 0; take = 0; cyc = 0;
    first_exp = 0; first_act = 0; first_at = -1;
    @(negedge clk);
    rate_hi = hi; dual_sc = dual; fast = fst;
    in_valid = (nbytes > 0); in_data = bytes[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int h = 0; h < nh; h++) begin
      int per, len;
      per = (!hs[h] && dual) ? 28 : 32;
      len = hs[h] ? na * 32 : (dual ? nb * 28 : na * 32);
      for (int t = 0; t < len; t++) begin
        logic e;
        if (take) begin
          idx++;
          in_valid = (idx < nbytes);
          in_data  = bytes[idx < 2 ? idx : 0];
          take = 0;
        end
        if (poke && cyc == 300) begin
          start = 1'b1; rate_hi = ~hi; dual_sc = ~dual; fast = 1'b0;
        end
        if (poke && cyc == 301) start = 1'b0;
        e = (hs[h] || dual) && ((t % per) < per / 2);
        if (mod_out !== e) begin
          if (first_at < 0) begin
            first_at = cyc; first_exp = e; first_act = mod_out;
          end
          mism++;
        end
        if (busy !== 1'b1) busy_bad++;
        if (in_ready === 1'b1) begin
          rdy_cnt++;
          take = 1;
        end
        cyc++;
        @(negedge clk);
      end
    end
    check(mism == 0, req, $sformatf("mod_out first wrong clock %0d, value", first_at),
          first_act, first_exp);
    check(busy_bad == 0, "R9", "clocks with busy low inside frame", busy_bad, 0);
    check(rdy_cnt == nbytes + 1, "R8", "in_ready pulses", rdy_cnt, nbytes + 1);
    check(busy == 1'b0 && mod_out == 1'b0, "R9", "busy after EOF", busy, 0);
    rate_hi = 1'b1; dual_sc = 1'b0; fast = 1'b0; in_valid = 1'b0; start = 1'b0;
  endtask

  task automatic t_reject();
    int seen;
    seen = 0;
    @(negedge clk);
    fast = 1'b1; dual_sc = 1'b1; rate_hi = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (busy !== 1'b0 || mod_out !== 1'b0) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R10", "clocks with activity after fast+dual start", seen, 0);
    fast = 1'b0; dual_sc = 1'b0;
  endtask

  initial begin
    #(190000 * 5);
    nfail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_frame(1'b1, 1'b0, 1'b0, 2, 8'hA5, 8'h3C, 1'b1, "R2 R3 R4 R6 R7 R11");
    run_frame(1'b1, 1'b1, 1'b0, 1, 8'h96, 8'h00, 1'b0, "R3 R5 R7");
    run_frame(1'b0, 1'b0, 1'b0, 1, 8'h0F, 8'h00, 1'b0, "R4 R6 low rate");
    run_frame(1'b0, 1'b1, 1'b0, 1, 8'hC3, 8'h00, 1'b1, "R5 R6 R11 low rate");
    run_frame(1'b1, 1'b0, 1'b1, 2, 8'h01, 8'hFE, 1'b0, "R6 fast");
    run_frame(1'b1, 1'b0, 1'b0, 0, 8'h00, 8'h00, 1'b0, "R7 R8 empty frame");
    t_reject();
    run_frame(1'b1, 1'b0, 1'b1, 1, 8'h5A, 8'h00, 1'b0, "R10 recovery");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule